// File: doc/BRIEF.md
# Flash Identification Readout Responder

This block is the identification answer engine inside a serial flash slave. It watches the serial clock, chip select and data lines, takes in the command byte, and answers the four identification requests with parameterised ID bytes. Those requests are the three-byte standard ID read, the legacy one-byte signature read that follows three dummy bytes, the manufacturer/device pair read, and the quad-wire ID read. The pair read follows two dummy bytes and an order-selecting address byte. Every other opcode, and any ID opcode that arrives while a program or erase is running, leaves the data lines released until chip select rises.

The pins are sampled with the system clock `clk`, through a synchroniser of `SYNC_STAGES` flops, so the serial clock must run well below the system clock. Data is taken in on serial-clock rising edges and driven out on falling edges, most significant bit first. In single-wire mode one bit moves per serial clock: input on `sio_i[0]` and output on `sio_o[1]`. In four-wire mode a nibble moves per clock on all four lines. The block has no flow control. The host paces the output with the serial clock, and raising chip select ends the transfer at any point.

Top module: `flash_id_responder`

## Requirements
- R1: After reset, and within 3 `clk` cycles of `cs_n_i` being seen high at the synchroniser output, `sio_oe_o` is 4'b0000.
- R2: In single-wire mode (`qpi_mode_i`=0), output bits appear on `sio_o[1]` with `sio_oe_o`=4'b0010. Output is most significant bit first, one bit per serial-clock falling edge. The first bit comes on the falling edge that follows the last header rising edge. `sio_i[3:1]` are ignored.
- R3: In four-wire mode (`qpi_mode_i`=1), input and output move four bits per serial clock on `sio[3:0]`, upper nibble first, with `sio_oe_o`=4'b1111.
- R4: Opcode 9Fh (single-wire only) outputs MFR_ID, MEM_TYPE, DENSITY (defaults C2h, 20h, 1Ah), then wraps to MFR_ID for as long as clocks continue.
- R5: Opcode ABh (either mode) is followed by 3 dummy bytes. It then outputs SIG_ID (default 19h), repeated for as long as clocks continue.
- R6: Opcode 90h (single-wire only) is followed by 2 dummy bytes and one address byte. If address bit 0 is 0, MFR_ID comes first, otherwise DEV_ID (default 19h) comes first. The two bytes then alternate until chip select rises.
- R7: Opcode AFh (four-wire only) outputs MFR_ID, MEM_TYPE, DENSITY right after the two command clocks, repeating continuously.
- R8: When `busy_i` is high at the rising edge that completes the opcode, nothing is driven until chip select rises.
- R9: Any other opcode, or an ID opcode in the wrong wire mode, leaves the lines released until chip select rises.
- R10: Raising chip select mid-byte ends the output. The next selection starts again from the opcode and the first ID byte.
- R11: `sio_oe_o` stays 4'b0000 during the opcode, dummy and address clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| qpi_mode_i | input | 1 | 1 = four-wire mode, 0 = single-wire mode; latched when chip select falls |
| busy_i | input | 1 | Program/erase in progress; blocks ID decoding |
| sck_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low chip select |
| sio_i | input | 4 | Serial data in (bit 0 only in single-wire mode) |
| sio_o | output | 4 | Serial data out |
| sio_oe_o | output | 4 | Per-line output enable |

## Verification
The hardest case to reach from the ports is a transfer that ends in the middle of an ID byte, followed by a new selection that must restart cleanly. Close behind it is a busy flag present exactly when the opcode completes. The bench drives directed transactions for each opcode in both wire modes, with wrap-around lengths and both pair orders. It adds a partial-byte abort followed by a fresh read, and opcodes sent in the wrong mode. A seeded random mix then varies opcode, mode, address bit, length, trailing partial bits and busy. Each byte read is compared with a bench-side table of the expected ID sequence.

// File: rtl/idr_pkg.sv
package idr_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_HDR, ST_DATA, ST_SKIP} idr_state_e;
  typedef enum logic [1:0] {ID_JEDEC, ID_SIG, ID_PAIR} idr_kind_e;

  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_SIG   = 8'hAB;
  localparam logic [7:0] OP_PAIR  = 8'h90;
  localparam logic [7:0] OP_QUAD  = 8'hAF;

  // number of distinct bytes before a sequence repeats
  function automatic logic [1:0] id_len(input idr_kind_e k);
    case (k)
      ID_JEDEC: id_len = 2'd3;
      ID_SIG:   id_len = 2'd1;
      default:  id_len = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/idr_front.sv
module idr_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_i,
  input  logic       cs_n_i,
  input  logic [3:0] sio_i,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       cs_hi,
  output logic [3:0] din
);
  localparam int unsigned W = 6;
  localparam logic [W-1:0] RST_VAL = 6'b010000;

  logic [SYNC_STAGES-1:0][W-1:0] stg;
  logic                          sck_prev;
  logic [W-1:0]                  last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg      <= {SYNC_STAGES{RST_VAL}};
      sck_prev <= 1'b0;
    end else begin
      stg[0] <= {sck_i, cs_n_i, sio_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      sck_prev <= stg[SYNC_STAGES-1][5];
    end
  end

  assign last     = stg[SYNC_STAGES-1];
  assign sck_rise = last[5] & ~sck_prev;
  assign sck_fall = ~last[5] & sck_prev;
  assign cs_hi    = last[4];
  assign din      = last[3:0];
endmodule

// File: rtl/idr_cmd_fsm.sv
module idr_cmd_fsm
  import idr_pkg::*;
#(
  parameter int unsigned SIG_DUMMY_BYTES  = 3,
  parameter int unsigned PAIR_DUMMY_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_rise,
  input  logic       cs_hi,
  input  logic [3:0] din,
  input  logic       qpi_mode_i,
  input  logic       busy_i,
  output logic       data_phase,
  output idr_kind_e  kind,
  output logic       sel,
  output logic       qpi_q
);
  localparam int unsigned SIG_HDR  = 8 * SIG_DUMMY_BYTES;
  localparam int unsigned PAIR_HDR = 8 * (PAIR_DUMMY_BYTES + 1);
  localparam int unsigned MAX_HDR  = (SIG_HDR > PAIR_HDR) ? SIG_HDR : PAIR_HDR;
  localparam int unsigned CW       = $clog2(MAX_HDR + 9);

  idr_state_e    state, dec_state;
  idr_kind_e     dec_kind;
  logic [7:0]    sr, sr_nxt;
  logic [CW-1:0] cnt, cnt_nxt, step, hdr_len, dec_len;
  logic          opc_done;

  assign step     = qpi_q ? CW'(4) : CW'(1);
  assign sr_nxt   = qpi_q ? {sr[3:0], din} : {sr[6:0], din[0]};
  assign cnt_nxt  = cnt + step;
  assign opc_done = (state == ST_OPC) && sck_rise && (cnt_nxt == CW'(8));

  always_comb begin
    dec_state = ST_SKIP;
    dec_kind  = ID_JEDEC;
    dec_len   = '0;
    if (!busy_i) begin
      case (sr_nxt)
        OP_JEDEC: if (!qpi_q) dec_state = ST_DATA;
        OP_QUAD:  if (qpi_q)  dec_state = ST_DATA;
        OP_SIG: begin
          dec_state = ST_HDR;
          dec_kind  = ID_SIG;
          dec_len   = CW'(SIG_HDR);
        end
        OP_PAIR: if (!qpi_q) begin
          dec_state = ST_HDR;
          dec_kind  = ID_PAIR;
          dec_len   = CW'(PAIR_HDR);
        end
        default: ;
      endcase
      if (dec_state == ST_HDR && dec_len == '0) dec_state = ST_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sr      <= '0;
      cnt     <= '0;
      hdr_len <= '0;
      kind    <= ID_JEDEC;
      sel     <= 1'b0;
      qpi_q   <= 1'b0;
    end else if (cs_hi) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_OPC;
          cnt   <= '0;
          sel   <= 1'b0;
          qpi_q <= qpi_mode_i;
        end
        ST_OPC: if (sck_rise) begin
          sr  <= sr_nxt;
          cnt <= cnt_nxt;
          if (opc_done) begin
            cnt     <= '0;
            state   <= dec_state;
            kind    <= dec_kind;
            hdr_len <= dec_len;
          end
        end
        ST_HDR: if (sck_rise) begin
          sr  <= sr_nxt;
          cnt <= cnt_nxt;
          if (cnt_nxt >= hdr_len) begin
            state <= ST_DATA;
            sel   <= sr_nxt[0];
          end
        end
        default: ;
      endcase
    end
  end

  assign data_phase = (state == ST_DATA);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_done && busy_i && !cs_hi) |=> (state == ST_SKIP));
  // R10
  cs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (state == ST_IDLE));
  // R5
  hdr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> (cnt < hdr_len));
endmodule

// File: rtl/idr_tx_shift.sv
module idr_tx_shift
  import idr_pkg::*;
#(
  parameter logic [7:0] MFR_ID   = 8'hC2,
  parameter logic [7:0] MEM_TYPE = 8'h20,
  parameter logic [7:0] DENSITY  = 8'h1A,
  parameter logic [7:0] SIG_ID   = 8'h19,
  parameter logic [7:0] DEV_ID   = 8'h19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_fall,
  input  logic       cs_hi,
  input  logic       data_phase,
  input  idr_kind_e  kind,
  input  logic       sel,
  input  logic       qpi,
  output logic [3:0] sio_o,
  output logic [3:0] sio_oe_o
);
  logic [1:0] idx, len;
  logic [2:0] bitpos;
  logic [7:0] cur;
  logic [3:0] chunk, out_q;
  logic       drive_q, wrap;

  assign len = id_len(kind);

  always_comb begin
    case (kind)
      ID_JEDEC: case (idx)
        2'd0:    cur = MFR_ID;
        2'd1:    cur = MEM_TYPE;
        default: cur = DENSITY;
      endcase
      ID_SIG:   cur = SIG_ID;
      default:  cur = (idx[0] ^ sel) ? DEV_ID : MFR_ID;
    endcase
  end

  always_comb begin
    if (qpi) chunk = bitpos[2] ? cur[7:4] : cur[3:0];
    else     chunk = {2'b00, cur[bitpos], 1'b0};
  end

  assign wrap = qpi ? !bitpos[2] : (bitpos == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      bitpos  <= 3'd7;
      drive_q <= 1'b0;
      out_q   <= '0;
    end else if (cs_hi || !data_phase) begin
      idx     <= '0;
      bitpos  <= 3'd7;
      drive_q <= 1'b0;
    end else if (sck_fall) begin
      drive_q <= 1'b1;
      out_q   <= chunk;
      if (wrap) begin
        bitpos <= 3'd7;
        idx    <= (idx == len - 2'd1) ? 2'd0 : idx + 2'd1;
      end else begin
        bitpos <= qpi ? 3'd3 : bitpos - 3'd1;
      end
    end
  end

  assign sio_o    = out_q;
  assign sio_oe_o = drive_q ? (qpi ? 4'b1111 : 4'b0010) : 4'b0000;

  // R1
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (sio_oe_o == 4'b0000));
  // R11
  hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |=> (sio_oe_o == 4'b0000));
  // R2
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(sck_fall));
  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx < len);
endmodule

// File: rtl/flash_id_responder.sv
module flash_id_responder
  import idr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES      = 2,
  parameter int unsigned SIG_DUMMY_BYTES  = 3,
  parameter int unsigned PAIR_DUMMY_BYTES = 2,
  parameter logic [7:0]  MFR_ID           = 8'hC2,
  parameter logic [7:0]  MEM_TYPE         = 8'h20,
  parameter logic [7:0]  DENSITY          = 8'h1A,
  parameter logic [7:0]  SIG_ID           = 8'h19,
  parameter logic [7:0]  DEV_ID           = 8'h19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qpi_mode_i,
  input  logic       busy_i,
  input  logic       sck_i,
  input  logic       cs_n_i,
  input  logic [3:0] sio_i,
  output logic [3:0] sio_o,
  output logic [3:0] sio_oe_o
);
  logic       sck_rise, sck_fall, cs_hi, data_phase, sel, qpi_q;
  logic [3:0] din;
  idr_kind_e  kind;

  idr_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .cs_n_i(cs_n_i), .sio_i(sio_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_hi(cs_hi), .din(din)
  );

  idr_cmd_fsm #(
    .SIG_DUMMY_BYTES(SIG_DUMMY_BYTES), .PAIR_DUMMY_BYTES(PAIR_DUMMY_BYTES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_hi(cs_hi), .din(din),
    .qpi_mode_i(qpi_mode_i), .busy_i(busy_i), .data_phase(data_phase),
    .kind(kind), .sel(sel), .qpi_q(qpi_q)
  );

  idr_tx_shift #(
    .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .DENSITY(DENSITY),
    .SIG_ID(SIG_ID), .DEV_ID(DEV_ID)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .cs_hi(cs_hi),
    .data_phase(data_phase), .kind(kind), .sel(sel), .qpi(qpi_q),
    .sio_o(sio_o), .sio_oe_o(sio_oe_o)
  );

  // R3
  mode_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe_o != 4'b0000) |-> (sio_oe_o == (qpi_q ? 4'b1111 : 4'b0010)));
endmodule

// File: tb/flash_id_responder_bench.sv
module flash_id_responder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       qpi_mode = 1'b0, busy = 1'b0, sck = 1'b0, cs_n = 1'b1;
  logic [3:0] sio_i = 4'h0;
  logic [3:0] sio_o, sio_oe;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  flash_id_responder u_flash_id_responder (
    .clk(clk), .rst_n(rst_n), .qpi_mode_i(qpi_mode), .busy_i(busy),
    .sck_i(sck), .cs_n_i(cs_n), .sio_i(sio_i), .sio_o(sio_o), .sio_oe_o(sio_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] op, input logic [7:0] addr, input int k);
    case (op)
      8'h9F, 8'hAF: exp_byte = (k % 3 == 0) ? 8'hC2 : (k % 3 == 1) ? 8'h20 : 8'h1A;
      8'hAB:        exp_byte = 8'h19;
      default:      exp_byte = (((k % 2) != 0) ^ addr[0]) ? 8'h19 : 8'hC2;
    endcase
  endfunction

  function automatic bit answers(input bit q, input logic [7:0] op, input bit bsy);
    answers = !bsy && ((op == 8'h9F && !q) || (op == 8'hAF && q) ||
                       op == 8'hAB || (op == 8'h90 && !q));
  endfunction

  // one serial clock: present data, sample output just before the rise
  task automatic pulse(input logic [3:0] din, output logic [3:0] dout, output logic [3:0] doe);
    @(negedge clk) sio_i = din;
    repeat (3) @(negedge clk);
    dout = sio_o;
    doe  = sio_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic send_byte(input bit q, input logic [7:0] b, inout bit quiet);
    logic [3:0] d, e;
    if (q) begin
      pulse(b[7:4], d, e); quiet &= (e == 4'h0);
      pulse(b[3:0], d, e); quiet &= (e == 4'h0);
    end else begin
      for (int i = 7; i >= 0; i--) begin
        pulse({3'($urandom), b[i]}, d, e);
        quiet &= (e == 4'h0);
      end
    end
  endtask

  task automatic xact(input bit q, input logic [7:0] op, input logic [7:0] addr,
                      input int nbytes, input int extra, input bit bsy, input string req);
    bit         quiet = 1'b1;
    bit         ans;
    logic [3:0] d, e;
    logic [7:0] got;
    ans = answers(q, op, bsy);
    @(negedge clk);
    qpi_mode = q; busy = bsy; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    send_byte(q, op, quiet);
    busy = 1'b0;
    if (ans && op == 8'hAB) for (int i = 0; i < 3; i++) send_byte(q, 8'($urandom), quiet);
    if (ans && op == 8'h90) begin
      send_byte(q, 8'($urandom), quiet);
      send_byte(q, 8'($urandom), quiet);
      send_byte(q, addr, quiet);
    end
    // R11
    check(quiet, {"R11 header quiet ", req}, 0, 0);
    for (int b = 0; b < nbytes; b++) begin
      bit oe_ok = 1'b1;
      got = '0;
      if (q) begin
        pulse(4'($urandom), d, e); got[7:4] = d; oe_ok &= ans ? (e == 4'hF) : (e == 4'h0);
        pulse(4'($urandom), d, e); got[3:0] = d; oe_ok &= ans ? (e == 4'hF) : (e == 4'h0);
      end else begin
        for (int i = 7; i >= 0; i--) begin
          pulse(4'($urandom), d, e);
          got[i] = d[1];
          oe_ok &= ans ? (e == 4'b0010) : (e == 4'h0);
        end
      end
      if (ans) begin
        check(oe_ok, {q ? "R3 enables " : "R2 enables ", req}, e, q ? 15 : 2);
        check(got == exp_byte(op, addr, b), {req, " byte"}, got, exp_byte(op, addr, b));
      end else begin
        check(oe_ok, {"R8/R9 released ", req}, e, 0);
      end
    end
    for (int i = 0; i < extra; i++) pulse(4'($urandom), d, e);
    @(negedge clk) cs_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1
    check(sio_oe == 4'h0, {"R1 cs high release ", req}, sio_oe, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(sio_oe == 4'h0, "R1 in reset", sio_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sio_oe == 4'h0, "R1 after reset", sio_oe, 0);

    xact(0, 8'h9F, 8'h00, 7, 0, 0, "R4 jedec wrap");
    xact(0, 8'hAB, 8'h00, 3, 0, 0, "R5 sig spi");
    xact(1, 8'hAB, 8'h00, 3, 0, 0, "R5 sig qpi");
    xact(0, 8'h90, 8'h00, 5, 0, 0, "R6 pair addr00");
    xact(0, 8'h90, 8'h01, 5, 0, 0, "R6 pair addr01");
    xact(0, 8'h90, 8'hFE, 3, 0, 0, "R6 pair addrFE");
    xact(1, 8'hAF, 8'h00, 6, 0, 0, "R7 quad id");
    xact(0, 8'hAF, 8'h00, 2, 0, 0, "R9 quad opcode in spi");
    xact(1, 8'h9F, 8'h00, 2, 0, 0, "R9 jedec in qpi");
    xact(1, 8'h90, 8'h00, 2, 0, 0, "R9 pair in qpi");
    xact(0, 8'h05, 8'h00, 2, 0, 0, "R9 foreign opcode");
    xact(0, 8'h9F, 8'h00, 2, 0, 1, "R8 busy jedec");
    xact(1, 8'hAB, 8'h00, 2, 0, 1, "R8 busy sig");
    xact(0, 8'h9F, 8'h00, 1, 5, 0, "R10 abort mid byte");
    xact(0, 8'h9F, 8'h00, 3, 0, 0, "R10 restart after abort");
    xact(1, 8'hAF, 8'h00, 0, 1, 0, "R10 abort qpi nibble");
    xact(1, 8'hAF, 8'h00, 3, 0, 0, "R10 restart qpi");

    for (int n = 0; n < 24; n++) begin
      logic [7:0] ops [5];
      logic [7:0] op;
      ops[0] = 8'h9F; ops[1] = 8'hAB; ops[2] = 8'h90; ops[3] = 8'hAF; ops[4] = 8'h3C;
      op = ops[$urandom % 5];
      xact(1'($urandom), op, 8'($urandom), 1 + int'($urandom % 5),
           int'($urandom % 4), ($urandom % 8) == 0, "R2 R3 random mix");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule